// File: doc/BRIEF.md
# Pulsed-Sync Serial Master

This block is a full-duplex serial master for words of 4 to 16 bits. Each word is framed by a single high pulse on a frame-sync line. The pulse lasts exactly one serial clock period and comes just before the word's most significant bit. Transmit words arrive on a valid/ready interface. Received words leave on a second valid/ready interface, which is offered for one cycle per word. The serial clock comes from the system clock through an even programmable divider. Its edges are produced as single-cycle internal strobes, so all logic runs in the system clock domain.

Between frames the serial clock and the frame-sync line rest low, and the data-out driver is disabled. When a word is taken, the sync period starts. The word's bits then follow MSB first, and both ends change data on rising serial edges and capture on falling edges. The received word is offered at the moment the next rising edge falls due after the LSB capture. If another transmit word is already waiting at that moment, that edge opens the next frame's sync period, so frames follow with no idle clocks between them.

Top module: `pss_master`

## Requirements
- R1: While no frame is in progress, `sclk`, `fsync` and `sdo_oe` are all 0 and `busy` is 0.
- R2: When a word is taken (`tx_valid` and `tx_ready` both high), `fsync` rises together with a rising `sclk` edge. It stays high for exactly one serial clock period and falls at the next rising edge.
- R3: The word is sent MSB first on `sdo`, starting at the rising edge after the sync period. The bits sent are `tx_data[L-1:0]`, where L is the effective word length. `sdo_oe` is 1 from the start of the sync period to the end of the frame.
- R4: `sdo` changes only at rising `sclk` edges. `sdi` is captured at falling `sclk` edges, one bit per data period.
- R5: The received word is offered (`rx_valid` high for one cycle) in the cycle before the rising edge that falls due after the LSB capture. If the sync pulse rose at system cycle c0, this is cycle c0 + 2·H·(L+1) − 1, where H is the effective half period. `rx_data` holds the L captured bits right-aligned, first-captured bit highest, and upper bits 0.
- R6: The effective word length is `cfg_len` sampled when a word is taken. Values below 4 count as 4 and values above 16 count as 16.
- R7: If a transmit word is valid when a frame's receive word is offered, the next sync pulse starts at the very next rising edge. That edge comes 2·H·(L+1) cycles after the previous sync rise.
- R8: The serial clock is high for H system cycles and low for H system cycles. H is `cfg_half` sampled when a word is taken, with 0 counting as 1.
- R9: `busy` is 1 from the sync rise until the receive offer. When no further word is pending, it returns to 0 in the cycle after the offer.
- R10: If `rx_ready` is 0 in the offer cycle, the word is dropped and `overrun` becomes 1. It stays 1 until reset.
- R11: `tx_ready` is high only in a cycle where a word is taken: at once while idle, or in the offer cycle of a running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len | input | 5 | Word length in bits, sampled when a word is taken |
| cfg_half | input | 8 | Serial half period in system cycles, sampled when a word is taken |
| tx_data | input | 16 | Transmit word, right-aligned |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit word taken this cycle |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | Received word offered this cycle |
| rx_ready | input | 1 | Receiver accepts the offered word |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame-sync pulse |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Frame in progress |
| overrun | output | 1 | Sticky dropped-receive flag |

## Verification
The assertions assume that `tx_valid` is held until `tx_ready` is seen. They also assume that the serial slave changes `sdi` only after a rising serial edge. The stimulus respects both: it raises `tx_valid` away from the clock edge and holds it until the word is taken, and it changes configuration only while no frame is in progress or pending. The bench models the slave by changing `sdi` at the system clock's falling edge after each rising `sclk`. This keeps the bit stable well ahead of the capture edge, even at a half period of one cycle.

// File: rtl/pss_pkg.sv
// Shared types for the pulsed-sync serial master.
// Assumes nothing beyond being compiled before the modules that import it.
package pss_pkg;

    // Strobes marking the system-clock cycle before a serial edge.
    typedef struct packed {
        logic rise_due;
        logic fall_due;
    } edge_due_t;

endpackage

// File: rtl/pss_clkgen.sv
// Serial clock generator. It holds the serial clock level and counts system
// cycles in each half period. It flags the cycle before each edge falls due.
// A rising edge happens only when the controller asks for it through go_rise.
// Assumes half >= 1; the controller clamps it.
module pss_clkgen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             go_rise,
    input  logic [DIV_W-1:0] half,
    output logic             sclk,
    output pss_pkg::edge_due_t due
);
    logic [DIV_W-1:0] cnt;
    logic             sclk_q;
    logic             cnt_end;

    // Half period ends on the last counted cycle.
    assign cnt_end      = (cnt == half - 1'b1);
    assign due.rise_due = active && !sclk_q && cnt_end;
    assign due.fall_due = active &&  sclk_q && cnt_end;
    assign sclk         = sclk_q;

    // Advance the half-period counter and the clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (go_rise) begin
            cnt    <= '0;
            sclk_q <= 1'b1;
        end else if (!active) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (cnt_end) begin
            cnt    <= '0;
            if (sclk_q) begin
                sclk_q <= 1'b0;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < half));
    p_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> $past(go_rise));

endmodule

// File: rtl/pss_shift.sv
// Transmit and receive shift registers. The transmit word is left-aligned at
// load so its MSB sits in the top bit. One bit goes out per shift_out strobe.
// One sdi bit comes in per capture strobe. The received word is masked to the
// latched length.
// Assumes load and shift_out are never asserted together.
module pss_shift #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic [LEN_W-1:0]  len_new,
    input  logic [LEN_W-1:0]  len_q,
    input  logic              shift_out,
    input  logic              capture,
    input  logic              sdi,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic              sdo_q;

    assign sdo = sdo_q;

    // Load the word left-aligned, or move the next bit onto the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            sdo_q <= 1'b0;
        end else if (load) begin
            tx_sh <= load_word << (DATA_W - int'(len_new));
            sdo_q <= 1'b0;
        end else if (shift_out) begin
            sdo_q <= tx_sh[DATA_W-1];
            tx_sh <= tx_sh << 1;
        end
    end

    // Collect incoming bits, first bit ending up highest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh <= '0;
        end else if (capture) begin
            rx_sh <= {rx_sh[DATA_W-2:0], sdi};
        end
    end

    // Keep only the bits of the current length.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign rx_word[i] = rx_sh[i] && (i < int'(len_q));
    end

    p_load_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sdo_q == 1'b0));

endmodule

// File: rtl/pss_ctrl.sv
// Frame sequencer. It tracks the sync period and the data periods and latches
// the configuration when a word is taken. It decides at each due rising edge
// whether to continue the frame, open a new frame, or stop. It also produces
// the handshake strobes and the sticky overrun flag.
// Assumes tx_valid is held until tx_ready is seen.
module pss_ctrl #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned LEN_W   = 5,
    parameter int unsigned MIN_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic             tx_valid,
    input  logic             rx_ready,
    input  pss_pkg::edge_due_t due,
    output logic             go_rise,
    output logic             active,
    output logic             fsync,
    output logic             sdo_oe,
    output logic             load,
    output logic             shift_out,
    output logic             capture,
    output logic [LEN_W-1:0] len_new,
    output logic [LEN_W-1:0] len_q,
    output logic [DIV_W-1:0] half_q,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic             overrun
);
    localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(DATA_W);

    logic [LEN_W-1:0] period;
    logic             last;
    logic             handoff;
    logic             start;
    logic [DIV_W-1:0] half_new;

    // Clamp the requested length and half period to their legal ranges.
    always_comb begin
        if (cfg_len < LEN_LO) begin
            len_new = LEN_LO;
        end else if (cfg_len > LEN_HI) begin
            len_new = LEN_HI;
        end else begin
            len_new = cfg_len;
        end
        half_new = (cfg_half == '0) ? DIV_W'(1) : cfg_half;
    end

    // Derive the per-cycle decisions from the due strobes.
    assign last      = active && (period == len_q);
    assign handoff   = due.rise_due && last;
    assign start     = tx_valid && (!active || handoff);
    assign go_rise   = start || (due.rise_due && !last);
    assign shift_out = due.rise_due && !last;
    assign capture   = due.fall_due && (period != '0);
    assign load      = start;
    assign tx_ready  = start;
    assign rx_valid  = handoff;

    // Step the period counter, sync pulse, enable and configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            active <= 1'b0;
            fsync  <= 1'b0;
            sdo_oe <= 1'b0;
            len_q  <= LEN_LO;
            half_q <= DIV_W'(1);
        end else if (start) begin
            period <= '0;
            active <= 1'b1;
            fsync  <= 1'b1;
            sdo_oe <= 1'b1;
            len_q  <= len_new;
            half_q <= half_new;
        end else if (shift_out) begin
            period <= period + 1'b1;
            fsync  <= 1'b0;
        end else if (handoff) begin
            active <= 1'b0;
            fsync  <= 1'b0;
            sdo_oe <= 1'b0;
        end
    end

    // Record a receive word that found no taker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (handoff && !rx_ready) begin
            overrun <= 1'b1;
        end
    end

    p_period_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (period <= len_q && len_q >= LEN_LO && len_q <= LEN_HI));
    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

// File: rtl/pss_master.sv
// Top of the pulsed-sync serial master. It connects the clock generator, the
// frame sequencer and the shift registers.
// Assumes the serial slave changes sdi only after rising sclk edges.
module pss_master #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned MIN_LEN = 4,
    localparam int unsigned LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [DIV_W-1:0]  cfg_half,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              sclk,
    output logic              fsync,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              sdi,
    output logic              busy,
    output logic              overrun
);
    pss_pkg::edge_due_t due;
    logic               go_rise;
    logic               active;
    logic               load;
    logic               shift_out;
    logic               capture;
    logic [LEN_W-1:0]   len_new;
    logic [LEN_W-1:0]   len_q;
    logic [DIV_W-1:0]   half_q;

    assign busy = active;

    pss_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .go_rise (go_rise),
        .half    (half_q),
        .sclk    (sclk),
        .due     (due)
    );

    pss_ctrl #(
        .DATA_W  (DATA_W),
        .DIV_W   (DIV_W),
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_len   (cfg_len),
        .cfg_half  (cfg_half),
        .tx_valid  (tx_valid),
        .rx_ready  (rx_ready),
        .due       (due),
        .go_rise   (go_rise),
        .active    (active),
        .fsync     (fsync),
        .sdo_oe    (sdo_oe),
        .load      (load),
        .shift_out (shift_out),
        .capture   (capture),
        .len_new   (len_new),
        .len_q     (len_q),
        .half_q    (half_q),
        .tx_ready  (tx_ready),
        .rx_valid  (rx_valid),
        .overrun   (overrun)
    );

    pss_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (tx_data),
        .len_new   (len_new),
        .len_q     (len_q),
        .shift_out (shift_out),
        .capture   (capture),
        .sdi       (sdi),
        .sdo       (sdo),
        .rx_word   (rx_data)
    );

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !fsync && !sdo_oe));
    p_sync_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync) |-> $rose(sclk));
    p_sync_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fsync) |-> $rose(sclk));
    p_sdo_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && (sdo != $past(sdo))) |-> $rose(sclk));
    p_offer_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!sclk && busy));
    p_take_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (tx_valid && (!busy || rx_valid)));

endmodule

// File: tb/pss_master_tb.sv
// Self-checking bench: random words and configurations with fixed seed, plus
// directed clamp, back-to-back and overrun cases. Models the serial slave.
module pss_master_tb;
    localparam int DATA_W = 16;
    localparam int DIV_W  = 8;
    localparam int LEN_W  = 5;
    localparam int NMAX   = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LEN_W-1:0]  cfg_len = 5'd8;
    logic [DIV_W-1:0]  cfg_half = 8'd1;
    logic [DATA_W-1:0] tx_data = '0;
    logic              tx_valid = 1'b0;
    logic              tx_ready;
    logic [DATA_W-1:0] rx_data;
    logic              rx_valid;
    logic              rx_ready = 1'b1;
    logic              sclk, fsync, sdo, sdo_oe, busy, overrun;
    logic              sdi = 1'b0;

    always #4 clk = ~clk;

    pss_master u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_half(cfg_half),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .sclk(sclk), .fsync(fsync), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi),
        .busy(busy), .overrun(overrun)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [DATA_W-1:0] tx_w [NMAX];
    logic [DATA_W-1:0] sl_w [NMAX];
    int eff_len [NMAX];
    int eff_half [NMAX];
    bit b2b_exp [NMAX];
    int fs_cyc [NMAX];
    int tx_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int exp_len(input int raw);
        return (raw < 4) ? 4 : ((raw > 16) ? 16 : raw);
    endfunction
    function automatic int exp_half(input int raw);
        return (raw == 0) ? 1 : raw;
    endfunction
    function automatic logic [DATA_W-1:0] lowbits(input logic [DATA_W-1:0] w, input int n);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < n; i++) m[i] = 1'b1;
        return w & m;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor and slave model, all at the falling system clock edge.
    bit prev_sclk = 0, prev_busy = 0;
    int sl_idx = 0, rx_idx = 0, cur = -1;
    int last_rise = 0, last_fall = 0, last_offer = -10;
    int ph = 0, mbits = 0, sl_bit = -1;
    logic [DATA_W-1:0] mword = '0;
    bit ovr_exp = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_ready) check(!busy || rx_valid, "R11 tx_ready mid-frame", busy, 0);
            if (sclk && !prev_sclk) begin
                if (fsync) begin
                    cur = sl_idx;
                    sl_idx++;
                    fs_cyc[cur] = cyc;
                    check(busy, "R9 busy at sync", busy, 1);
                    check(sdo_oe, "R3 oe at sync", sdo_oe, 1);
                    if (cur > 0 && b2b_exp[cur])
                        check(cyc == fs_cyc[cur-1] + 2*eff_half[cur-1]*(eff_len[cur-1]+1),
                              "R7 back-to-back sync", cyc - fs_cyc[cur-1], 2*eff_half[cur-1]*(eff_len[cur-1]+1));
                    ph = 0; mbits = 0; mword = '0;
                    sl_bit = eff_len[cur] - 1;
                end else begin
                    check(cyc - last_fall == eff_half[cur], "R8 low width", cyc - last_fall, eff_half[cur]);
                    if (ph == 0) check(cyc - fs_cyc[cur] == 2*eff_half[cur] && !fsync,
                                      "R2 sync width", cyc - fs_cyc[cur], 2*eff_half[cur]);
                    ph++;
                    if (sl_bit >= 0) begin
                        sdi = sl_w[cur][sl_bit];
                        sl_bit--;
                    end
                end
                last_rise = cyc;
            end
            if (!sclk && prev_sclk) begin
                check(cyc - last_rise == eff_half[cur], "R8 high width", cyc - last_rise, eff_half[cur]);
                if (ph >= 1 && ph <= eff_len[cur]) begin
                    mword = {mword[DATA_W-2:0], sdo};
                    mbits++;
                    if (mbits == eff_len[cur])
                        check(mword == lowbits(tx_w[cur], eff_len[cur]), "R3 bits sent MSB first",
                              mword, lowbits(tx_w[cur], eff_len[cur]));
                end
                last_fall = cyc;
            end
            if (ovr_exp) begin
                check(overrun, "R10 overrun set", overrun, 1);
                ovr_exp = 0;
            end
            if (rx_valid) begin
                check(cyc == fs_cyc[rx_idx] + 2*eff_half[rx_idx]*(eff_len[rx_idx]+1) - 1,
                      "R5 offer cycle", cyc - fs_cyc[rx_idx], 2*eff_half[rx_idx]*(eff_len[rx_idx]+1) - 1);
                check(!sclk, "R4 offer while low", sclk, 0);
                if (rx_ready)
                    check(rx_data == lowbits(sl_w[rx_idx], eff_len[rx_idx]), "R5 rx word",
                          rx_data, lowbits(sl_w[rx_idx], eff_len[rx_idx]));
                else ovr_exp = 1;
                rx_idx++;
                last_offer = cyc;
            end
            if (prev_busy && !busy) begin
                check(cyc == last_offer + 1, "R9 busy drop", cyc - last_offer, 1);
                check(!sclk && !fsync && !sdo_oe, "R1 idle lines", {sclk, fsync, sdo_oe}, 0);
            end
        end
        prev_sclk = sclk;
        prev_busy = busy;
    end

    task automatic send_group(input int raw_len, input int raw_half, input int n, input bit b2b);
        while (rx_idx < tx_cnt || busy) @(negedge clk);
        repeat (2) @(negedge clk);
        cfg_len = LEN_W'(raw_len);
        cfg_half = DIV_W'(raw_half);
        for (int k = 0; k < n; k++) begin
            tx_w[tx_cnt] = DATA_W'($urandom);
            sl_w[tx_cnt] = DATA_W'($urandom);
            eff_len[tx_cnt] = exp_len(raw_len);
            eff_half[tx_cnt] = exp_half(raw_half);
            b2b_exp[tx_cnt] = b2b && (k > 0);
            tx_data = tx_w[tx_cnt];
            tx_valid = 1'b1;
            #1;
            while (!tx_ready) begin
                @(negedge clk);
                #1;
            end
            @(negedge clk);
            tx_cnt++;
            tx_valid = 1'b0;
            tx_data = '0;
            if (!b2b) begin
                while (rx_idx < tx_cnt || busy) @(negedge clk);
                repeat ($urandom_range(1, 5)) @(negedge clk);
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        check(!sclk && !fsync && !sdo_oe && !busy, "R1 reset idle", {sclk, fsync, sdo_oe, busy}, 0);
        check(!overrun && !tx_ready && !rx_valid, "R10 reset flags", {overrun, tx_ready, rx_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        send_group(8, 2, 3, 1);
        send_group(16, 1, 4, 1);
        send_group(4, 3, 2, 0);
        send_group(2, 0, 3, 1);      // R6 low clamp, R8 zero half
        send_group(25, 1, 2, 0);     // R6 high clamp
        for (int g = 0; g < 8; g++)
            send_group($urandom_range(4, 16), $urandom_range(1, 4), $urandom_range(1, 4), 1'($urandom_range(0, 1)));
        check(!overrun, "R10 no overrun yet", overrun, 0);
        while (rx_idx < tx_cnt || busy) @(negedge clk);
        rx_ready = 1'b0;
        send_group(6, 1, 1, 0);
        while (rx_idx < tx_cnt || busy) @(negedge clk);
        rx_ready = 1'b1;
        send_group(12, 2, 2, 1);
        while (rx_idx < tx_cnt || busy) @(negedge clk);
        repeat (4) @(negedge clk);
        check(overrun, "R10 overrun sticky", overrun, 1);
        check(rx_idx == tx_cnt, "R5 all words offered", rx_idx, tx_cnt);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", rx_idx, tx_cnt);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule